// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory. A host toggles the clock line and drives its data line. The block watches both lines and drives its own data output, which is released (high) or pulled low. It keeps an internal byte array whose size is set by a parameter. Transfers open with a start condition and close with a stop condition. A device byte follows each start; its least significant bit picks read or write. After that come zero, one or two address bytes, then a stream of data bytes. The block acknowledges every byte the host sends, and the address pointer advances after every data byte.

The array size picks how the address is formed. For arrays under 256 bytes, the device byte itself holds the address and the data phase follows at once. For arrays of 256 to 4095 bytes, three bits of the device byte carry the upper address and one extra byte carries the lower eight bits. For larger arrays, two address bytes follow: high, then low. A read always starts at the current pointer. To read from a chosen location, the host first sends a write header with the address, then a repeated start and a read header. Both lines are brought into the block's clock domain before any edge is recognised. The array size must be a power of two, from 4 to 65536 bytes.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high (and was high in the previous sample) is a start condition. It aborts any transfer, releases `sda_o`, and begins a new 8-bit device byte. Bits already shifted in for an interrupted data byte are not written.
- R2: A rising data line while the clock line is high is a stop condition. It returns the block to idle and releases `sda_o`. While idle, clock pulses and data changes without a start leave `sda_o` released.
- R3: Host bits are sampled on clock rising edges, most significant bit first. After the eighth bit of any host byte, the block pulls `sda_o` low from the next clock falling edge until the falling edge after it. This is the acknowledge slot.
- R4: A device byte with bit 0 = 1 selects read. Data comes from the current pointer, most significant bit first, with each bit placed on `sda_o` at a clock falling edge. The first bit appears at the falling edge that ends the device-byte acknowledge.
- R5: For an array smaller than 256 bytes, a write device byte sets the pointer to device-byte bits 7:1, truncated to the array's address width. Data bytes follow directly.
- R6: For an array of 256 to 4095 bytes, a write device byte puts its bits 3:1 in pointer bits 10:8. One address byte then supplies pointer bits 7:0. Bits beyond the array's address width are dropped.
- R7: For an array of 4096 bytes or more, a write device byte is followed by a high address byte (pointer bits 15:8) and then a low address byte (pointer bits 7:0). Bits beyond the array's address width are dropped.
- R8: Each data byte written is stored at the pointer on its eighth rising clock edge. On the rising edge of each data acknowledge slot, written or read, the pointer advances by one and wraps from the last location to 0. A read then fetches the byte at the new pointer.
- R9: After reset every array byte reads 0xFF, the pointer is 0 and `sda_o` is released.
- R10: `sda_bus_o` is the wired AND of the host data line `sda_i` and `sda_o`.
- R11: The host's level in the acknowledge slot after a read byte is ignored. Reading continues with the next byte until a start or stop condition arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the host, asynchronous |
| sda_i | input | 1 | Data level driven by the host, asynchronous |
| sda_o | output | 1 | Target data drive: 0 pulls the line low, 1 releases it |
| sda_bus_o | output | 1 | Resolved data line, `sda_i` AND `sda_o` |

## Verification
The situation hardest to reach from the ports is a pointer wrap combined with the size-dependent address forms. A high address bit that the array cannot hold must really be dropped, and a write that runs past the last location must land at address 0. The bench runs three instances of different sizes side by side and drives each bus to the last locations of its array, using address bytes whose upper bits lie beyond the address width. It fills the smallest array completely and reads it back across the wrap. It also breaks a data byte with a repeated start, and issues a stop while the target is driving a zero. This shows that partial bytes are discarded and that the stop releases the line.

// File: rtl/i2c_ee_pkg.sv
// Package: shared types and size thresholds for the two-wire EEPROM target.
// Assumes: array sizes are powers of two.
package i2c_ee_pkg;

    // Protocol phases of the target controller
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WR,
        ST_WR_ACK
    } ee_state_t;

    // How the write header builds the pointer
    typedef enum logic [1:0] {
        AM_DEVBYTE,
        AM_SPLIT,
        AM_TWOBYTE
    } addr_mode_t;

    localparam int SPLIT_MIN_BYTES   = 256;
    localparam int TWOBYTE_MIN_BYTES = 4096;

    // Picks the address form from the array size
    function automatic addr_mode_t mode_for(input int bytes);
        if (bytes < SPLIT_MIN_BYTES)        return AM_DEVBYTE;
        else if (bytes < TWOBYTE_MIN_BYTES) return AM_SPLIT;
        else                                return AM_TWOBYTE;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings asynchronous bus lines into the clock domain.
// Each line gets two synchronising flops and one flop holding the previous
// synchronised level, so callers can detect edges.
// Assumes: lines idle high; reset loads the idle level.
module i2c_line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] prev_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Two-stage synchroniser followed by a history flop
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= raw_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level_o[g] = sync_q;
        assign prev_o[g]  = prev_q;
    end

endmodule

// File: rtl/i2c_ee_array.sv
// Module: byte storage for the EEPROM target.
// One synchronous write port and one combinational read port.
// Assumes: DEPTH is a power of two; reset fills every byte with 0xFF.
module i2c_ee_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];

    // Erased contents on reset, otherwise single-byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Asynchronous read of the addressed byte
    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/i2c_ee_ctrl.sv
// Module: protocol controller of the EEPROM target.
// It takes decoded bus events (clock edges, start, stop) and the
// synchronised host data bit. It runs the byte phases, the bit counter,
// the shift latch and the pointer, and it drives the target's data output.
// Assumes: events are single-cycle pulses; start and stop never coincide.
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_bit_i,
    input  logic [7:0]    rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          sda_o,
    output ee_state_t     state_o,
    output logic [3:0]    cnt_o
);

    localparam addr_mode_t MODE = mode_for(MEM_BYTES);
    localparam logic [3:0] BITS = 4'd8;

    ee_state_t     state_q;
    logic [3:0]    cnt_q;
    logic [7:0]    latch_q;
    logic [AW-1:0] ptr_q;
    logic          sda_q;

    logic [7:0]    shift_in;
    logic          last_bit;
    logic [AW-1:0] ptr_inc;
    logic [15:0]   hi_addr;
    logic [15:0]   lo_addr;
    logic [15:0]   dev_addr;
    ee_state_t     dev_next;

    // Next latch value, last-bit flag and incremented pointer
    assign shift_in = {latch_q[6:0], sda_bit_i};
    assign last_bit = (cnt_q == 4'd1);
    assign ptr_inc  = ptr_q + AW'(1);
    assign hi_addr  = {shift_in, 8'h00};
    assign lo_addr  = 16'(ptr_q) | {8'h00, shift_in};

    // Size-dependent handling of a write device byte
    if (MODE == AM_DEVBYTE) begin : g_devbyte
        assign dev_addr = {9'd0, latch_q[7:1]};
        assign dev_next = ST_WR;
    end else if (MODE == AM_SPLIT) begin : g_split
        assign dev_addr = {5'd0, latch_q[3:1], 8'h00};
        assign dev_next = ST_ALO;
    end else begin : g_twobyte
        assign dev_addr = 16'(ptr_q);
        assign dev_next = ST_AHI;
    end

    // Array write strobe on the eighth bit of a data byte
    assign we_o    = scl_rise_i && !start_i && !stop_i
                     && (state_q == ST_WR) && last_bit;
    assign waddr_o = ptr_q;
    assign wdata_o = shift_in;

    // Read address: the next location while a read acknowledge is pending
    assign raddr_o = (state_q == ST_RD_ACK) ? ptr_inc : ptr_q;

    // Phase sequencing, bit counting, latch, pointer and data drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= 4'd0;
            latch_q <= 8'h00;
            ptr_q   <= '0;
            sda_q   <= 1'b1;
        end else if (start_i) begin
            state_q <= ST_START;
            cnt_q   <= BITS;
            sda_q   <= 1'b1;
        end else if (stop_i) begin
            state_q <= ST_IDLE;
            sda_q   <= 1'b1;
        end else if (scl_rise_i) begin
            unique case (state_q)
                ST_START, ST_AHI, ST_ALO, ST_WR: begin
                    latch_q <= shift_in;
                    cnt_q   <= cnt_q - 4'd1;
                    if (last_bit) begin
                        case (state_q)
                            ST_START: state_q <= ST_DEV_ACK;
                            ST_AHI: begin
                                ptr_q   <= hi_addr[AW-1:0];
                                state_q <= ST_AHI_ACK;
                            end
                            ST_ALO: begin
                                ptr_q   <= lo_addr[AW-1:0];
                                state_q <= ST_ALO_ACK;
                            end
                            default: state_q <= ST_WR_ACK;
                        endcase
                    end
                end
                ST_DEV_ACK: begin
                    cnt_q <= BITS;
                    if (latch_q[0]) begin
                        state_q <= ST_RD;
                        latch_q <= rdata_i;
                    end else begin
                        state_q <= dev_next;
                        ptr_q   <= dev_addr[AW-1:0];
                    end
                end
                ST_AHI_ACK: begin
                    state_q <= ST_ALO;
                    cnt_q   <= BITS;
                end
                ST_ALO_ACK: begin
                    state_q <= ST_WR;
                    cnt_q   <= BITS;
                end
                ST_RD: begin
                    cnt_q <= cnt_q - 4'd1;
                    if (last_bit) state_q <= ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    state_q <= ST_RD;
                    cnt_q   <= BITS;
                    ptr_q   <= ptr_inc;
                    latch_q <= rdata_i;
                end
                ST_WR_ACK: begin
                    state_q <= ST_WR;
                    cnt_q   <= BITS;
                    ptr_q   <= ptr_inc;
                end
                default: ;
            endcase
        end else if (scl_fall_i) begin
            unique case (state_q)
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_RD_ACK, ST_WR_ACK:
                    sda_q <= 1'b0;
                ST_RD: begin
                    sda_q   <= latch_q[7];
                    latch_q <= {latch_q[6:0], 1'b0};
                end
                default: sda_q <= 1'b1;
            endcase
        end
    end

    assign sda_o   = sda_q;
    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
// Module: top of the two-wire serial EEPROM target.
// It synchronises the bus lines, decodes clock edges and start/stop
// conditions, and connects the controller to the byte array.
// Assumes: MEM_BYTES is a power of two between 4 and 65536.
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int MEM_BYTES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic sda_bus_o
);

    localparam int AW = $clog2(MEM_BYTES);

    logic [1:0]    lvl;
    logic [1:0]    prv;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_evt;
    logic          stop_evt;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;
    ee_state_t     fsm_state;
    logic [3:0]    fsm_cnt;

    // Line 0 carries the clock, line 1 the host data
    i2c_line_sync #(.LINES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_i, scl_i}),
        .level_o (lvl),
        .prev_o  (prv)
    );

    // Bus event decode from current and previous synchronised levels
    assign scl_rise  =  lvl[0] & ~prv[0];
    assign scl_fall  = ~lvl[0] &  prv[0];
    assign start_evt =  lvl[0] &  prv[0] &  prv[1] & ~lvl[1];
    assign stop_evt  =  lvl[0] &  prv[0] & ~prv[1] &  lvl[1];

    i2c_ee_ctrl #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .sda_bit_i  (lvl[1]),
        .rdata_i    (rdata),
        .raddr_o    (raddr),
        .we_o       (we),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .sda_o      (sda_o),
        .state_o    (fsm_state),
        .cnt_o      (fsm_cnt)
    );

    i2c_ee_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    // Open-drain resolution of the data line
    assign sda_bus_o = sda_i & sda_o;

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
// Module: property checker for the EEPROM target, attached by bind.
// Assumes: it sees the top's decoded events and controller state.
module i2c_eeprom_target_chk
    import i2c_ee_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_o,
    input logic       scl_fall,
    input logic       start_evt,
    input logic       stop_evt,
    input ee_state_t  state,
    input logic [3:0] bit_cnt
);

    // R3
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_o));

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_START && sda_o && bit_cnt == 4'd8));

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && sda_o));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sda_o);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    // R9
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sda_o && state == ST_IDLE));

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_o     (sda_o),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .state     (fsm_state),
    .bit_cnt   (fsm_cnt)
);

// File: tb/i2c_eeprom_target_test.sv
// Bench: three targets (64, 512 and 4096 bytes), one for each address form,
// each on its own bus and driven by shared bus tasks.
module i2c_eeprom_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] scl = 3'b111;
    logic [2:0] sdah = 3'b111;
    logic [2:0] sdat;
    logic [2:0] sdab;
    int         checks = 0;
    int         fails = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_target #(.MEM_BYTES(64)) uut_s (
        .clk(clk), .rst_n(rst_n), .scl_i(scl[0]), .sda_i(sdah[0]),
        .sda_o(sdat[0]), .sda_bus_o(sdab[0]));
    i2c_eeprom_target #(.MEM_BYTES(512)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl[1]), .sda_i(sdah[1]),
        .sda_o(sdat[1]), .sda_bus_o(sdab[1]));
    i2c_eeprom_target #(.MEM_BYTES(4096)) uut_w (
        .clk(clk), .rst_n(rst_n), .scl_i(scl[2]), .sda_i(sdah[2]),
        .sda_o(sdat[2]), .sda_bus_o(sdab[2]));

    function automatic logic [7:0] pat1(int a); return 8'((a * 7 + 3) & 255); endfunction
    function automatic logic [7:0] pat2(int k); return 8'((k * 29 + 17) & 255); endfunction
    function automatic logic [7:0] pat3(int k); return 8'((k * 53 + 64) & 255); endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    // Checks the wired-AND output at the current sample point (R10)
    task automatic check_bus(int i);
        check("R10 wired AND", {7'd0, sdab[i]}, {7'd0, sdah[i] & sdat[i]});
    endtask

    task automatic bus_start(int i);
        sdah[i] = 1'b1; hold();
        scl[i] = 1'b1;  hold();
        sdah[i] = 1'b0; hold();
        check("R1 released after start", {7'd0, sdat[i]}, 8'd1);
        scl[i] = 1'b0;  hold();
    endtask

    task automatic bus_stop(int i);
        sdah[i] = 1'b0; hold();
        scl[i] = 1'b1;  hold();
        sdah[i] = 1'b1; hold();
        check("R2 released after stop", {7'd0, sdat[i]}, 8'd1);
    endtask

    task automatic send_bits(int i, logic [7:0] b, int n);
        for (int k = 7; k > 7 - n; k--) begin
            sdah[i] = b[k]; hold();
            scl[i] = 1'b1;  hold();
            scl[i] = 1'b0;  hold();
        end
    endtask

    // Sends one byte and checks the target's acknowledge (R3)
    task automatic send_byte(int i, logic [7:0] b);
        send_bits(i, b, 8);
        sdah[i] = 1'b1; hold();
        scl[i] = 1'b1;  hold();
        check("R3 acknowledge low", {7'd0, sdab[i]}, 8'd0);
        check_bus(i);
        scl[i] = 1'b0;  hold();
    endtask

    // Receives one byte; the host's acknowledge level varies (R11)
    task automatic recv_byte(int i, logic nack, output logic [7:0] b);
        sdah[i] = 1'b1;
        for (int k = 7; k >= 0; k--) begin
            scl[i] = 1'b1; hold();
            b[k] = sdab[i];
            scl[i] = 1'b0; hold();
        end
        sdah[i] = nack; hold();
        scl[i] = 1'b1;  hold();
        check("R3 target low in read acknowledge", {7'd0, sdat[i]}, 8'd0);
        scl[i] = 1'b0;  hold();
        sdah[i] = 1'b1;
    endtask

    task automatic read_expect(int i, string tag, logic nack, logic [7:0] exp);
        logic [7:0] got;
        recv_byte(i, nack, got);
        check(tag, got, exp);
    endtask

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        // R9: outputs released during reset
        check("R9 reset drive s", {7'd0, sdat[0]}, 8'd1);
        check("R9 reset drive m", {7'd0, sdat[1]}, 8'd1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 released after reset", {5'd0, sdat}, 8'h07);
        sdah[1] = 1'b0; @(negedge clk);
        check_bus(1);
        sdah[1] = 1'b1; @(negedge clk);

        // R2: clock activity while idle leaves the line released
        for (int n = 0; n < 10; n++) begin
            scl[0] = 1'b0; hold();
            sdah[0] = n[0]; hold();
            scl[0] = 1'b1; hold();
            check("R2 idle ignores clocks", {7'd0, sdat[0]}, 8'd1);
        end
        scl[0] = 1'b0; sdah[0] = 1'b1; hold();
        scl[0] = 1'b1; hold();

        // Small array: R5 pointer from device byte, fill all, wrap read (R8)
        bus_start(0);
        send_byte(0, 8'h00);
        for (int a = 0; a < 64; a++) send_byte(0, pat1(a));
        bus_stop(0);
        bus_start(0);
        send_byte(0, 8'h01);
        for (int a = 0; a < 66; a++) read_expect(0, "R8 R4 small fill/wrap read", a[0], pat1(a % 64));
        // next byte is pat1(2)=0x11: MSB 0 is being driven now
        check("R4 MSB driven on falling edge", {7'd0, sdat[0]}, 8'd0);
        bus_stop(0);
        // R5: device byte 0xFE gives pointer 0x7F truncated to 0x3F
        bus_start(0);
        send_byte(0, 8'hFE);
        send_byte(0, 8'hA5);
        bus_stop(0);
        bus_start(0);
        send_byte(0, 8'h7E);
        bus_stop(0);
        bus_start(0);
        send_byte(0, 8'h01);
        read_expect(0, "R5 truncated device address", 1'b0, 8'hA5);
        read_expect(0, "R8 wrap to zero", 1'b1, pat1(0));
        bus_stop(0);

        // Mid array: erased contents from pointer 0 with host nack (R9, R11)
        bus_start(1);
        send_byte(1, 8'hA1);
        for (int k = 0; k < 4; k++) read_expect(1, "R9 R11 erased read", 1'b1, 8'hFF);
        bus_stop(1);
        // R6: device bits 3:1=101 -> bit 8 set, bits 10:9 dropped; addr 0x1FC
        bus_start(1);
        send_byte(1, 8'hAA);
        send_byte(1, 8'hFC);
        for (int k = 0; k < 8; k++) send_byte(1, pat2(k));
        bus_stop(1);
        bus_start(1);
        send_byte(1, 8'hAA);
        send_byte(1, 8'hFC);
        bus_start(1);
        send_byte(1, 8'hA1);
        for (int k = 0; k < 8; k++) read_expect(1, "R6 R8 split address wrap", k[0], pat2(k));
        read_expect(1, "R8 past written area", 1'b0, 8'hFF);
        bus_stop(1);
        // R6: 0x0FC must not have been written
        bus_start(1);
        send_byte(1, 8'hA0);
        send_byte(1, 8'hFC);
        bus_start(1);
        send_byte(1, 8'hA1);
        read_expect(1, "R6 upper bit selects half", 1'b1, 8'hFF);
        bus_stop(1);
        // R6: device bits 3:1=110 -> address 0x010 (bits 10:9 dropped)
        bus_start(1);
        send_byte(1, 8'hAC);
        send_byte(1, 8'h10);
        send_byte(1, 8'h5A);
        bus_stop(1);
        // R1: a start inside a data byte discards the partial bits
        bus_start(1);
        send_byte(1, 8'hA0);
        send_byte(1, 8'h20);
        send_bits(1, 8'h00, 5);
        bus_start(1);
        send_byte(1, 8'hA0);
        send_byte(1, 8'h10);
        bus_start(1);
        send_byte(1, 8'hA1);
        read_expect(1, "R6 dropped device bits", 1'b0, 8'h5A);
        bus_stop(1);
        bus_start(1);
        send_byte(1, 8'hA0);
        send_byte(1, 8'h20);
        bus_start(1);
        send_byte(1, 8'hA1);
        read_expect(1, "R1 aborted byte not written", 1'b1, 8'hFF);
        bus_stop(1);

        // Wide array: R7 two address bytes, wrap at 0xFFF (R8)
        bus_start(2);
        send_byte(2, 8'hA0);
        send_byte(2, 8'hFF);
        send_byte(2, 8'hFE);
        for (int k = 0; k < 4; k++) send_byte(2, pat3(k));
        bus_stop(2);
        bus_start(2);
        send_byte(2, 8'hA0);
        send_byte(2, 8'hFF);
        send_byte(2, 8'hFE);
        bus_start(2);
        send_byte(2, 8'hA1);
        for (int k = 0; k < 4; k++) read_expect(2, "R7 R8 two-byte address wrap", 1'b0, pat3(k));
        read_expect(2, "R8 wide past written area", 1'b1, 8'hFF);
        bus_stop(2);
        bus_start(2);
        send_byte(2, 8'hA0);
        send_byte(2, 8'h12);
        send_byte(2, 8'h34);
        send_byte(2, 8'hC3);
        bus_stop(2);
        bus_start(2);
        send_byte(2, 8'hA0);
        send_byte(2, 8'h12);
        send_byte(2, 8'h33);
        bus_start(2);
        send_byte(2, 8'hA1);
        read_expect(2, "R7 neighbour erased", 1'b0, 8'hFF);
        read_expect(2, "R7 written byte", 1'b1, 8'hC3);
        bus_stop(2);
        // R7: high-byte bits above the width are dropped (0x02 aliases 0x12)
        bus_start(2);
        send_byte(2, 8'hA0);
        send_byte(2, 8'h02);
        send_byte(2, 8'h34);
        bus_start(2);
        send_byte(2, 8'hA1);
        recv_byte(2, 1'b1, d);
        check("R7 high bits dropped", d, 8'hC3);
        bus_stop(2);

        done = 1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule